// File: doc/BRIEF.md
# Shared-Pin Configurable I/O Port

This block is one eight-pin port that a microcontroller bus and an on-chip programmable logic array share. Software places three writable registers at fixed byte offsets: a control word, a direction word and a data-out word. It reads the pins back through a synchronised data-in path. Each pin then takes its output value from one of four sources. These are the data-out register for plain microcontroller I/O, a logic-array output, a latched address bit, or a peripheral pass-through.

The block drives a value and an output enable for every pin to the external tri-state pads. A pin's direction is the OR of its software direction bit and the logic array's output-enable term for that pin. Two static configuration inputs sit beside the registers. The first is a per-pin strap that hands a pin to the logic array. The second is a port-wide peripheral-mode bit that overrides everything else. A build parameter removes the control register for ports that only ever run as microcontroller or logic-array I/O.

Top module: `cfg_io_port`

## Requirements
- R1: After reset the control, direction and data-out registers read as 0, so with all logic-array enables low every pin is an input (padOe = 0) in microcontroller mode.
- R2: A write strobe with busAddr 2 loads the control register, 4 loads data-out and 6 loads direction, on the clock edge of the strobe. Reads at those offsets return the stored word. Writes to any other offset (0, 1, 3, 5, 7) change nothing, and reads at odd offsets return 0.
- R3: Outside peripheral mode, padOe[i] is direction bit i (1 = output, 0 = input) ORed with logicOe[i].
- R4: A pin whose control bit is 0 and whose logic strap is 0 drives data-out bit i on padOut[i].
- R5: A pin whose control bit is 1 is in address-output mode and drives latchedAddr[i]; it reaches the pad when direction bit i is 1.
- R6: A pin whose control bit is 0 and whose strap pldModeSel[i] is 1 drives logicOut[i], and is tri-stated whenever direction bit i and logicOe[i] are both 0.
- R7: A control bit of 1 takes priority over the logic strap on the same pin.
- R8: While periphMode is 1, every pin drives periphOut[i] with enable periphOe[i], regardless of the registers and straps.
- R9: A read at offset 0 returns padIn through two flops. A pin change seen at one edge shows on busRdData after the second edge, not after the first.
- R10: With HAS_CTRL = 0 the control register does not exist. Offset 2 reads 0, writes there are ignored, and pins select only between data-out and the logic strap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register byte offset |
| busWrEn | input | 1 | Single-cycle write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr |
| padIn | input | 8 | Live pin levels from the pads |
| logicOut | input | 8 | Logic-array output per pin |
| logicOe | input | 8 | Logic-array output-enable term per pin |
| pldModeSel | input | 8 | Static strap giving a pin to the logic array |
| latchedAddr | input | 8 | Latched address bits for address-output pins |
| periphMode | input | 1 | Port-wide peripheral pass-through select |
| periphOut | input | 8 | Peripheral output values |
| periphOe | input | 8 | Peripheral output enables |
| padOut | output | 8 | Value driven to each pad |
| padOe | output | 8 | Output enable for each pad |

## Verification
Pad values and enables are pure combinational functions of the registers and the static inputs. A change on a strap, enable or peripheral input therefore shows in the same cycle. A register write shows in the cycle that follows its strobe edge. The data-in path is due two edges after a pin change. The bench checks it after one edge, expecting the old value, and after the second, expecting the new one. The driver changes inputs only half a period away from the active edge. Each queued expectation is compared on the falling edge of the cycle in which its result is due.

// File: rtl/iop_pkg.sv
package iop_pkg;
  localparam int unsigned OFS_DIN  = 0;
  localparam int unsigned OFS_CTRL = 2;
  localparam int unsigned OFS_DOUT = 4;
  localparam int unsigned OFS_DIR  = 6;

  typedef enum logic [1:0] {
    SEL_DIN  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DOUT = 2'd2,
    SEL_DIR  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrCtrl;
    logic    wrDout;
    logic    wrDir;
    logic    rdValid;
    regSel_e rdSel;
  } iopStrobe_t;
endpackage

// File: rtl/iop_ctrl.sv
module iop_ctrl
  import iop_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter bit          HAS_CTRL = 1'b1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output iopStrobe_t        stb
);
  always_comb begin
    stb       = '0;
    stb.rdSel = SEL_DIN;
    case (busAddr)
      ADDR_W'(OFS_DIN): begin
        stb.rdValid = 1'b1;
        stb.rdSel   = SEL_DIN;
      end
      ADDR_W'(OFS_CTRL): begin
        stb.rdValid = 1'b1;
        stb.rdSel   = SEL_CTRL;
        stb.wrCtrl  = busWrEn && HAS_CTRL;
      end
      ADDR_W'(OFS_DOUT): begin
        stb.rdValid = 1'b1;
        stb.rdSel   = SEL_DOUT;
        stb.wrDout  = busWrEn;
      end
      ADDR_W'(OFS_DIR): begin
        stb.rdValid = 1'b1;
        stb.rdSel   = SEL_DIR;
        stb.wrDir   = busWrEn;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/iop_datapath.sv
module iop_datapath
  import iop_pkg::*;
#(
  parameter int unsigned WIDTH    = 8,
  parameter bit          HAS_CTRL = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  iopStrobe_t       stb,
  input  logic [WIDTH-1:0] busWrData,
  input  logic [WIDTH-1:0] padIn,
  input  logic [WIDTH-1:0] logicOut,
  input  logic [WIDTH-1:0] logicOe,
  input  logic [WIDTH-1:0] pldModeSel,
  input  logic [WIDTH-1:0] latchedAddr,
  input  logic             periphMode,
  input  logic [WIDTH-1:0] periphOut,
  input  logic [WIDTH-1:0] periphOe,
  output logic [WIDTH-1:0] busRdData,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] ctrlQ,
  output logic [WIDTH-1:0] dirQ,
  output logic [WIDTH-1:0] doutQ
);
  logic [WIDTH-1:0] syncA;
  logic [WIDTH-1:0] syncB;

  generate
    if (HAS_CTRL) begin : g_ctrl
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           ctrlQ <= '0;
        else if (stb.wrCtrl) ctrlQ <= busWrData;
      end
    end else begin : g_noCtrl
      assign ctrlQ = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ  <= '0;
      doutQ <= '0;
      syncA <= '0;
      syncB <= '0;
    end else begin
      if (stb.wrDir)  dirQ  <= busWrData;
      if (stb.wrDout) doutQ <= busWrData;
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  always_comb begin
    busRdData = '0;
    if (stb.rdValid) begin
      case (stb.rdSel)
        SEL_DIN:  busRdData = syncB;
        SEL_CTRL: busRdData = ctrlQ;
        SEL_DOUT: busRdData = doutQ;
        SEL_DIR:  busRdData = dirQ;
        default:  busRdData = '0;
      endcase
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign padOut[i] = periphMode  ? periphOut[i]   :
                       ctrlQ[i]    ? latchedAddr[i] :
                       pldModeSel[i] ? logicOut[i]  : doutQ[i];
    assign padOe[i]  = periphMode ? periphOe[i] : (dirQ[i] | logicOe[i]);
  end
endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port
  import iop_pkg::*;
#(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned ADDR_W   = 3,
  parameter bit          HAS_CTRL = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [WIDTH-1:0]  busWrData,
  output logic [WIDTH-1:0]  busRdData,
  input  logic [WIDTH-1:0]  padIn,
  input  logic [WIDTH-1:0]  logicOut,
  input  logic [WIDTH-1:0]  logicOe,
  input  logic [WIDTH-1:0]  pldModeSel,
  input  logic [WIDTH-1:0]  latchedAddr,
  input  logic              periphMode,
  input  logic [WIDTH-1:0]  periphOut,
  input  logic [WIDTH-1:0]  periphOe,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe
);
  iopStrobe_t       stb;
  logic [WIDTH-1:0] ctrlQ;
  logic [WIDTH-1:0] dirQ;
  logic [WIDTH-1:0] doutQ;

  iop_ctrl #(.ADDR_W(ADDR_W), .HAS_CTRL(HAS_CTRL)) u_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .stb    (stb)
  );

  iop_datapath #(.WIDTH(WIDTH), .HAS_CTRL(HAS_CTRL)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .busWrData  (busWrData),
    .padIn      (padIn),
    .logicOut   (logicOut),
    .logicOe    (logicOe),
    .pldModeSel (pldModeSel),
    .latchedAddr(latchedAddr),
    .periphMode (periphMode),
    .periphOut  (periphOut),
    .periphOe   (periphOe),
    .busRdData  (busRdData),
    .padOut     (padOut),
    .padOe      (padOe),
    .ctrlQ      (ctrlQ),
    .dirQ       (dirQ),
    .doutQ      (doutQ)
  );
endmodule

// File: rtl/iop_checker.sv
module iop_checker
  import iop_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [WIDTH-1:0]  busWrData,
  input logic [WIDTH-1:0]  busRdData,
  input logic [WIDTH-1:0]  padIn,
  input logic [WIDTH-1:0]  logicOe,
  input logic [WIDTH-1:0]  pldModeSel,
  input logic              periphMode,
  input logic [WIDTH-1:0]  periphOut,
  input logic [WIDTH-1:0]  periphOe,
  input logic [WIDTH-1:0]  padOut,
  input logic [WIDTH-1:0]  padOe,
  input logic [WIDTH-1:0]  ctrlQ,
  input logic [WIDTH-1:0]  dirQ,
  input logic [WIDTH-1:0]  doutQ
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
  end

  assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFS_DIR)) |=>
      (periphMode || padOe == ($past(busWrData) | logicOe)));

  assert_dout_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFS_DOUT)) |=> doutQ == $past(busWrData));

  assert_odd_write_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[0]) |=> ($stable(ctrlQ) && $stable(dirQ) && $stable(doutQ)));

  assert_mcu_out_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!periphMode && ctrlQ == '0 && pldModeSel == '0) |-> padOut == doutQ);

  assert_periph_override_R8: assert property (@(posedge clk) disable iff (!rstN)
    periphMode |-> (padOut == periphOut && padOe == periphOe));

  assert_sync_depth_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd2 && busAddr == ADDR_W'(OFS_DIN)) |-> busRdData == $past(padIn, 2));
endmodule

bind cfg_io_port iop_checker #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .padIn     (padIn),
  .logicOe   (logicOe),
  .pldModeSel(pldModeSel),
  .periphMode(periphMode),
  .periphOut (periphOut),
  .periphOe  (periphOe),
  .padOut    (padOut),
  .padOe     (padOe),
  .ctrlQ     (ctrlQ),
  .dirQ      (dirQ),
  .doutQ     (doutQ)
);

// File: tb/cfg_io_port_test.sv
module cfg_io_port_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] padIn = '0, logicOut = '0, logicOe = '0, pldModeSel = '0;
  logic [7:0] latchedAddr = '0, periphOut = '0, periphOe = '0;
  logic       periphMode = 1'b0;
  logic [7:0] busRdData, padOut, padOe;
  logic [7:0] ncRdData, ncPadOut, ncPadOe;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  typedef struct {
    string      req;
    int         sel;
    logic [7:0] exp;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  cfg_io_port uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .logicOut(logicOut), .logicOe(logicOe), .pldModeSel(pldModeSel),
    .latchedAddr(latchedAddr), .periphMode(periphMode), .periphOut(periphOut),
    .periphOe(periphOe), .padOut(padOut), .padOe(padOe)
  );

  cfg_io_port #(.HAS_CTRL(1'b0)) uutNc (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(ncRdData), .padIn(padIn),
    .logicOut(logicOut), .logicOe(logicOe), .pldModeSel(pldModeSel),
    .latchedAddr(latchedAddr), .periphMode(periphMode), .periphOut(periphOut),
    .periphOe(periphOe), .padOut(ncPadOut), .padOe(ncPadOe)
  );

  // monitor: compares queued expectations on the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.sel)
        0:       act = padOut;
        1:       act = padOe;
        2:       act = busRdData;
        3:       act = ncRdData;
        default: act = ncPadOut;
      endcase
      nChecks++;
      if (act !== it.exp) begin
        nFail++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic expectAt(input int sel, input logic [7:0] exp, input string req);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic expectRd(input logic [2:0] a, input int sel, input logic [7:0] exp,
                          input string req);
    busAddr = a;
    #1;
    expectAt(sel, exp, req);
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic stepClk();
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    stepClk();
    // R1: reset state
    expectRd(3'd2, 2, 8'h00, "R1 control after reset");
    expectRd(3'd4, 2, 8'h00, "R1 data-out after reset");
    expectRd(3'd6, 2, 8'h00, "R1 direction after reset");
    expectAt(1, 8'h00, "R1 all pins input");
    // R4, R2: data-out drives pins in mcu mode
    busWrite(3'd4, 8'hA5);
    expectAt(0, 8'hA5, "R4 mcu output from data-out");
    expectRd(3'd4, 2, 8'hA5, "R2 data-out readback");
    // R3: direction and OR with logic enable
    busWrite(3'd6, 8'h0F);
    expectAt(1, 8'h0F, "R3 direction drives enable");
    expectRd(3'd6, 2, 8'h0F, "R2 direction readback");
    logicOe = 8'h30;
    expectAt(1, 8'h3F, "R3 enable is dir OR logicOe");
    // R6: logic strap
    pldModeSel = 8'hF0; logicOut = 8'h5A;
    expectAt(0, 8'h55, "R6 logic-array output on strapped pins");
    expectAt(1, 8'h3F, "R6 strapped pins 7,6 tri-stated");
    expectAt(4, 8'h55, "R10 no-ctrl variant output");
    // R5, R7: address-output mode overrides strap
    latchedAddr = 8'h81;
    busWrite(3'd2, 8'hC3);
    expectAt(0, 8'h95, "R5 R7 address bits and priority over strap");
    expectRd(3'd2, 2, 8'hC3, "R2 control readback");
    expectRd(3'd2, 3, 8'h00, "R10 control absent reads 0");
    expectAt(4, 8'h55, "R10 no-ctrl variant ignores control write");
    // R2: writes at unused offsets ignored
    busWrite(3'd1, 8'hFF);
    busWrite(3'd0, 8'hFF);
    busWrite(3'd7, 8'hFF);
    expectRd(3'd2, 2, 8'hC3, "R2 control unchanged by stray write");
    expectRd(3'd4, 2, 8'hA5, "R2 data-out unchanged by stray write");
    expectRd(3'd6, 2, 8'h0F, "R2 direction unchanged by stray write");
    expectRd(3'd1, 2, 8'h00, "R2 odd offset reads 0");
    expectAt(0, 8'h95, "R2 pins unchanged by stray write");
    // R8: peripheral override
    periphOut = 8'h3C; periphOe = 8'hE1; periphMode = 1'b1;
    expectAt(0, 8'h3C, "R8 peripheral output");
    expectAt(1, 8'hE1, "R8 peripheral enable");
    periphMode = 1'b0;
    expectAt(1, 8'h3F, "R8 release restores enable");
    // R9: two-flop data-in
    busAddr = 3'd0;
    padIn = 8'h6B;
    stepClk();
    expectRd(3'd0, 2, 8'h00, "R9 data-in not yet after one edge");
    expectRd(3'd0, 2, 8'h6B, "R9 data-in after two edges");
    expectRd(3'd0, 3, 8'h6B, "R9 no-ctrl variant data-in");
    done = 1'b1;
    @(negedge clk); #1;
    summary();
    $finish;
  end
endmodule